// File: doc/BRIEF.md
# Multiplexed Backplane Transmit Capture

This block takes a byte-interleaved serial transmit bus from the system side and extracts the bytes that belong to one line link. The bus clock, framing pulse, data line and signaling line all arrive as ordinary signals. A faster internal clock samples them, and rising and falling bus-clock edges are detected synchronously, so the whole block runs in one clock domain.

A frame holds `NUM_TS` bus timeslots of 8 bits each. The link owns every `LANES`-th bus timeslot, and `lane_i` selects which one. Configuration inputs choose the following:
- which bus-clock edge samples the framing pulse;
- which edge samples data and signaling;
- single-rate or double-rate clocking, and in double-rate mode which edge of each bit period is used;
- framing-pulse polarity;
- a bit offset and a timeslot offset between the pulse and the start of the frame.

For each link timeslot the block presents the assembled data byte, the matching signaling byte and the link timeslot index, qualified by a one-cycle strobe.

Top module: `tx_bus_capture`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first framing pulse has aligned the frame, `valid_o` stays low.
- R2: The framing pulse is sampled only on bus-clock edges of the type set by `fp_edge_i` (0 rising, 1 falling). The frame start is taken from the first such sample where the pulse is active and the previous sample was inactive.
- R3: Data and signaling are sampled on edges of the type set by `dat_edge_i` (0 rising, 1 falling). When `dat_edge_i` equals `fp_edge_i`, the edge that detects the pulse also carries bit period 0.
- R4: When `dat_edge_i` differs from `fp_edge_i`, the pulse counts as arriving half a clock ahead. Bit period 0 is then the first data edge after the pulse edge.
- R5: With `dbl_rate_i` high, each bit period has two data-type edges, counted from the pulse. `dbl_sel_i` = 0 samples on the first of them and 1 on the second. The pulse is always detected on its first active edge.
- R6: With `fp_inv_i` low the framing pulse is active high. With `fp_inv_i` high it is active low.
- R7: Frame bit 0 is sampled `ts_off_i*8 + bit_off_i` bit periods after bit period 0, and frame bits then follow one per bit period.
- R8: Frame bit f lies in bus timeslot f/8. That timeslot belongs to the link when (f/8) mod `LANES` equals `lane_i`, and its link timeslot is (f/8)/`LANES`. Bytes are assembled MSB first, so the first bit received lands in bit 7.
- R9: `valid_o` is high for exactly one cycle, the cycle after the eighth bit of a link timeslot is sampled. `byte_o`, `sig_o` and `ts_o` carry that timeslot and hold until the next strobe.
- R10: No strobe is given for a byte whose first bit came before the alignment. A later framing pulse that agrees with the running frame count leaves the output stream unbroken.
- R11: The signaling line is assembled with the same timing and bit order as the data, so `sig_o` belongs to the same timeslot as `byte_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_clk_i | input | 1 | System bus bit clock, sampled |
| bus_fp_i | input | 1 | Framing pulse |
| bus_dat_i | input | 1 | Serial data line |
| bus_sig_i | input | 1 | Serial signaling line |
| fp_edge_i | input | 1 | Pulse sampling edge, 0 rising, 1 falling |
| dat_edge_i | input | 1 | Data sampling edge, 0 rising, 1 falling |
| dbl_rate_i | input | 1 | Bus clock at twice the bit rate |
| dbl_sel_i | input | 1 | Double rate: 0 first edge, 1 second edge |
| fp_inv_i | input | 1 | Pulse active low when high |
| bit_off_i | input | 3 | Bit offset 0..7 |
| ts_off_i | input | $clog2(NUM_TS) | Timeslot offset 0..NUM_TS-1 |
| lane_i | input | $clog2(LANES) | Bus timeslot lane of the link |
| valid_o | output | 1 | One-cycle byte strobe |
| byte_o | output | 8 | Assembled data byte |
| sig_o | output | 8 | Assembled signaling byte |
| ts_o | output | $clog2(NUM_TS)-$clog2(LANES) | Link timeslot index |

## Verification
The bench builds the block with `NUM_TS` = 16 and `LANES` = 4. This gives a 128-bit frame with four link timeslots, so two full frames take only a few thousand cycles. At that size the bench can sweep all 32 combinations of pulse edge, data edge, rate, edge select and polarity, and vary the lane, the bit offset and the full timeslot offset range in each run, including the largest offset. Every run sends a second pulse one frame later to confirm that a consistent realignment keeps the stream intact. Offsets near the frame boundary also exercise partial-byte suppression.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  // clk in bit 0
  typedef struct packed {
    logic sig;
    logic dat;
    logic fp;
    logic clk;
  } bus_t;

  localparam int unsigned BUS_LINES = $bits(bus_t);

  function automatic logic pick_edge(edge_e sel, logic rise, logic fall);
    return (sel == EDGE_FALL) ? fall : rise;
  endfunction

endpackage

// File: rtl/tbc_edge_sync.sv
module tbc_edge_sync
  import tbc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  bus_t bus_i,
  output bus_t bus_o,
  output logic rise_o,
  output logic fall_o
);

  logic [BUS_LINES-1:0] in_v;
  logic [BUS_LINES-1:0] out_v;
  logic                 clk_prev_q;

  assign in_v = bus_i;

  genvar g;
  for (g = 0; g < BUS_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[SYNC_STAGES-2:0], in_v[g]};
    end
    assign out_v[g] = stage_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= out_v[0];
  end

  assign bus_o  = bus_t'(out_v);
  assign rise_o = out_v[0] & ~clk_prev_q;
  assign fall_o = ~out_v[0] & clk_prev_q;

endmodule

// File: rtl/tbc_bit_timer.sv
module tbc_bit_timer
  import tbc_pkg::*;
#(
  parameter int unsigned FB_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            fp_i,
  input  edge_e           fp_edge_i,
  input  edge_e           dat_edge_i,
  input  logic            dbl_i,
  input  logic            dbl_sel_i,
  input  logic            fp_inv_i,
  input  logic [FB_W-1:0] off_i,
  output logic            tick_o,
  output logic            bit_o,
  output logic [FB_W-1:0] pos_o,
  output logic            slip_o,
  output logic            locked_o
);

  logic            fp_last_q, half_q, arm_q, locked_q;
  logic [FB_W-1:0] pos_q;
  logic            fp_act, fp_evt, de_evt, start, eff_half, tick, arm_now, slip;
  logic [FB_W-1:0] neg_off, pos_step, pos_cur;

  always_comb begin
    fp_act   = fp_i ^ fp_inv_i;
    fp_evt   = pick_edge(fp_edge_i, rise_i, fall_i);
    de_evt   = pick_edge(dat_edge_i, rise_i, fall_i);
    start    = fp_evt && fp_act && !fp_last_q;
    // pulse edge is half 0 of its bit period
    eff_half = start ? 1'b0 : half_q;
    tick     = de_evt && (!dbl_i || (eff_half == dbl_sel_i));
    arm_now  = start || arm_q;
    neg_off  = '0 - off_i;
    pos_step = pos_q + 1'b1;
    pos_cur  = arm_now ? neg_off : pos_step;
    slip     = arm_now && (!locked_q || (neg_off != pos_step));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_last_q <= 1'b0;
      half_q    <= 1'b0;
      arm_q     <= 1'b0;
      locked_q  <= 1'b0;
      pos_q     <= '0;
    end else begin
      if (fp_evt) fp_last_q <= fp_act;
      if (de_evt)     half_q <= ~eff_half;
      else if (start) half_q <= 1'b0;
      if (tick) begin
        pos_q <= pos_cur;
        arm_q <= 1'b0;
        if (arm_now) locked_q <= 1'b1;
      end else begin
        arm_q <= arm_now;
      end
    end
  end

  assign tick_o   = tick;
  assign bit_o    = tick && (locked_q || arm_now);
  assign pos_o    = pos_cur;
  assign slip_o   = tick && slip;
  assign locked_o = locked_q;

endmodule

// File: rtl/tbc_byte_pack.sv
module tbc_byte_pack #(
  parameter int unsigned FB_W   = 10,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned LTS_W  = FB_W - 3 - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic [FB_W-1:0]   pos_i,
  input  logic              slip_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              dat_i,
  input  logic              sig_i,
  output logic              valid_o,
  output logic [7:0]        byte_o,
  output logic [7:0]        sig_o,
  output logic [LTS_W-1:0]  ts_o
);

  logic [6:0]       dsh_q, ssh_q;
  logic             have_q, have_d, hit, last_bit;
  logic             valid_q;
  logic [7:0]       byte_q, sig_q;
  logic [LTS_W-1:0] ts_q;
  logic [2:0]       bit_idx;

  always_comb begin
    bit_idx  = pos_i[2:0];
    hit      = bit_i && (pos_i[LANE_W+2:3] == lane_i);
    have_d   = have_q;
    if (slip_i) have_d = 1'b0;
    if (hit && (bit_idx == 3'd0)) have_d = 1'b1;
    last_bit = hit && (bit_idx == 3'd7) && have_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsh_q   <= '0;
      ssh_q   <= '0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
      byte_q  <= '0;
      sig_q   <= '0;
      ts_q    <= '0;
    end else begin
      have_q  <= have_d;
      valid_q <= last_bit;
      if (hit) begin
        dsh_q <= {dsh_q[5:0], dat_i};
        ssh_q <= {ssh_q[5:0], sig_i};
      end
      if (last_bit) begin
        byte_q <= {dsh_q, dat_i};
        sig_q  <= {ssh_q, sig_i};
        ts_q   <= pos_i[FB_W-1:LANE_W+3];
      end
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;
  assign sig_o   = sig_q;
  assign ts_o    = ts_q;

endmodule

// File: rtl/tx_bus_capture.sv
module tx_bus_capture
  import tbc_pkg::*;
#(
  parameter int unsigned NUM_TS      = 128,
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      bus_clk_i,
  input  logic                                      bus_fp_i,
  input  logic                                      bus_dat_i,
  input  logic                                      bus_sig_i,
  input  logic                                      fp_edge_i,
  input  logic                                      dat_edge_i,
  input  logic                                      dbl_rate_i,
  input  logic                                      dbl_sel_i,
  input  logic                                      fp_inv_i,
  input  logic [2:0]                                bit_off_i,
  input  logic [$clog2(NUM_TS)-1:0]                 ts_off_i,
  input  logic [$clog2(LANES)-1:0]                  lane_i,
  output logic                                      valid_o,
  output logic [7:0]                                byte_o,
  output logic [7:0]                                sig_o,
  output logic [$clog2(NUM_TS)-$clog2(LANES)-1:0]   ts_o
);

  localparam int unsigned TS_W   = $clog2(NUM_TS);
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned FB_W   = TS_W + 3;
  localparam int unsigned LTS_W  = TS_W - LANE_W;

  bus_t            bus_raw, bus_s;
  logic            edge_rise, edge_fall;
  logic            bit_tick, bit_aligned, slip, locked;
  logic [FB_W-1:0] pos;

  assign bus_raw = '{sig: bus_sig_i, dat: bus_dat_i, fp: bus_fp_i, clk: bus_clk_i};

  tbc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_raw),
    .bus_o  (bus_s),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  tbc_bit_timer #(.FB_W(FB_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (edge_rise),
    .fall_i     (edge_fall),
    .fp_i       (bus_s.fp),
    .fp_edge_i  (edge_e'(fp_edge_i)),
    .dat_edge_i (edge_e'(dat_edge_i)),
    .dbl_i      (dbl_rate_i),
    .dbl_sel_i  (dbl_sel_i),
    .fp_inv_i   (fp_inv_i),
    .off_i      ({ts_off_i, bit_off_i}),
    .tick_o     (bit_tick),
    .bit_o      (bit_aligned),
    .pos_o      (pos),
    .slip_o     (slip),
    .locked_o   (locked)
  );

  tbc_byte_pack #(.FB_W(FB_W), .LANE_W(LANE_W), .LTS_W(LTS_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_aligned),
    .pos_i   (pos),
    .slip_i  (slip),
    .lane_i  (lane_i),
    .dat_i   (bus_s.dat),
    .sig_i   (bus_s.sig),
    .valid_o (valid_o),
    .byte_o  (byte_o),
    .sig_o   (sig_o),
    .ts_o    (ts_o)
  );

endmodule

// File: rtl/tbc_checker.sv
module tbc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rise_i,
  input logic fall_i,
  input logic tick_i,
  input logic locked_i,
  input logic valid_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_i); // R1
    end
  end

  AST_NO_STROBE_UNALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> !valid_i); // R1

  AST_TICK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (rise_i || fall_i)); // R3

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i); // R9

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(tick_i)); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> locked_i); // R10

endmodule

bind tx_bus_capture tbc_checker u_tbc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rise_i   (edge_rise),
  .fall_i   (edge_fall),
  .tick_i   (bit_tick),
  .locked_i (locked),
  .valid_i  (valid_o)
);

// File: tb/tx_bus_capture_bench.sv
module tx_bus_capture_bench;

  localparam int NUM_TS = 16;
  localparam int LANES  = 4;
  localparam int TS_W   = $clog2(NUM_TS);
  localparam int LANE_W = $clog2(LANES);
  localparam int FB     = NUM_TS * 8;
  localparam int NLINK  = NUM_TS / LANES;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_clk = 1'b0, bus_fp = 1'b0, bus_dat = 1'b0, bus_sig = 1'b0;
  logic fp_edge = 1'b0, dat_edge = 1'b0, dbl_rate = 1'b0, dbl_sel = 1'b0, fp_inv = 1'b0;
  logic [2:0] bit_off = '0;
  logic [TS_W-1:0] ts_off = '0;
  logic [LANE_W-1:0] lane = '0;
  logic valid_o;
  logic [7:0] byte_o, sig_o;
  logic [TS_W-LANE_W-1:0] ts_o;

  int errs = 0, checks = 0, cyc = 0;
  int r_off, r_lane, n0, got, seen0;
  string tag;

  always #2 clk_i = ~clk_i;

  tx_bus_capture #(.NUM_TS(NUM_TS), .LANES(LANES)) u_tx_bus_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_clk_i(bus_clk), .bus_fp_i(bus_fp),
    .bus_dat_i(bus_dat), .bus_sig_i(bus_sig), .fp_edge_i(fp_edge), .dat_edge_i(dat_edge),
    .dbl_rate_i(dbl_rate), .dbl_sel_i(dbl_sel), .fp_inv_i(fp_inv), .bit_off_i(bit_off),
    .ts_off_i(ts_off), .lane_i(lane), .valid_o(valid_o), .byte_o(byte_o), .sig_o(sig_o),
    .ts_o(ts_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] xb(int n, int t);
    return 8'(t * 29 + (n + 1) * 83 + 17);
  endfunction

  function automatic logic [7:0] xs(int n, int t);
    return 8'(t * 53 + (n + 1) * 7 + 101);
  endfunction

  // value on the line for bit period k (R7, R8, R11)
  function automatic logic bitv(int k, bit is_sig);
    int f, n, fm, bts;
    logic [7:0] b;
    f = k - r_off;
    n = (f < 0) ? -1 : f / FB;
    fm = f - n * FB;
    bts = fm / 8;
    if (bts % LANES == r_lane) begin
      b = is_sig ? xs(n, bts / LANES) : xb(n, bts / LANES);
      return b[7 - fm % 8];
    end
    return is_sig ? 1'((fm * 7) >> 1) : 1'((fm * 13) >> 2);
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic mon();
    int n, t;
    @(negedge clk_i);
    if (rst_ni && valid_o) begin
      if (seen0 == 0 && ts_o == 0) seen0 = 1;
      if (seen0 != 0) begin
        n = n0 + got / NLINK;
        t = got % NLINK;
        chk(ts_o == t, {tag, " R9 ts"}, int'(ts_o), t);
        chk(byte_o == xb(n, t), {tag, " R8 byte"}, int'(byte_o), int'(xb(n, t)));
        chk(sig_o == xs(n, t), {tag, " R11 sig"}, int'(sig_o), int'(xs(n, t)));
        got++;
      end
    end
  endtask

  task automatic run(bit fe, bit de, bit dbl, bit sel, bit inv, int tso, int bo, int ln);
    int j0, jd0, kmax, jend, jf, jd, m, pk, d, k;
    logic act;
    rst_ni = 1'b0;
    bus_clk = 1'b0; bus_dat = 1'b0; bus_sig = 1'b0; bus_fp = inv;
    fp_edge = fe; dat_edge = de; dbl_rate = dbl; dbl_sel = sel; fp_inv = inv;
    ts_off = TS_W'(tso); bit_off = 3'(bo); lane = LANE_W'(ln);
    r_off = tso * 8 + bo; r_lane = ln;
    n0 = (r_off > 0 && (FB - r_off) <= ln * 8) ? -1 : 0;
    got = 0; seen0 = 0;
    tag = $sformatf("%s%s%s R7 fe=%0d de=%0d dbl=%0d sel=%0d inv=%0d off=%0d lane=%0d",
                    (fe == de) ? "R2 R3" : "R2 R4", dbl ? " R5" : "", inv ? " R6" : "",
                    fe, de, dbl, sel, inv, r_off, ln);
    repeat (3) mon();
    chk(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (3) mon();
    j0 = 4 + fe;
    jd0 = (fe == de) ? j0 : j0 + 1;
    kmax = r_off + 2 * FB - 1;
    jend = jd0 + 2 * (dbl ? 2 * kmax + 1 : kmax);
    for (int j = 0; j <= jend; j++) begin
      mon();
      jf = ((j & 1) == fe) ? j : j + 1;
      act = 1'b0;
      if (jf >= j0) begin
        m = (jf - j0) / 2;
        pk = dbl ? m / 2 : m;
        act = (pk == 0 || pk == FB);
      end
      bus_fp = act ^ inv;
      jd = ((j & 1) == de) ? j : j + 1;
      if (jd >= jd0) begin
        d = (jd - jd0) / 2;
        k = dbl ? d / 2 : d;
        bus_dat = bitv(k, 1'b0);
        bus_sig = bitv(k, 1'b1);
      end else begin
        bus_dat = 1'b0;
        bus_sig = 1'b0;
      end
      mon();
      bus_clk = ~bus_clk;
    end
    repeat (12) mon();
    chk(got == (2 - n0) * NLINK, {tag, " R10 R9 strobe count"}, got, (2 - n0) * NLINK);
  endtask

  initial begin
    for (int idx = 0; idx < 32; idx++) begin
      run(idx[0], idx[1], idx[2], idx[3], idx[4], (idx * 5) % NUM_TS, (idx * 3) % 8, (idx * 3) % LANES);
    end
    run(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, NUM_TS - 1, 7, LANES - 1);
    run(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, NUM_TS - 1, 7, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule